// File: doc/BRIEF.md
# SPI Slave Motor Command Decoder

This block is a serial peripheral that lets a host controller drive a small motor stage over SPI. The host clocks bytes into it with chip select low. The block watches the byte stream for one of two synchronising command bytes. It then gathers a three-byte frame and acts on it. A frame can zero the two external 16-bit quadrature counters through a one-cycle strobe. It can also queue a readback of either counter, or load the two 8-bit PWM duty values. The duty values are clamped to a safe window before they reach the PWM generators.

The serial pins are oversampled by the fabric clock through synchronisers, so the system clock must run several times faster than the serial clock (eight or more is comfortable). Replies go out one byte per transfer, in whatever transfers the host starts after the command. When no reply is queued, a fixed filler byte goes out.

Top module: `spi_cmd_decoder`

## Requirements
- R1: The interface is a slave in SPI mode 1 (clock idles low, the slave drives `miso` after each rising `sclk` edge and samples `mosi` on each falling edge), and it shifts the most significant bit first in both directions.
- R2: Every transfer for which no reply byte is queued shifts out the filler byte 0xEE, including the first transfer after reset.
- R3: While no frame is being gathered, received bytes other than 0xAA and 0x55 are ignored. A frame starts only on one of those two values.
- R4: A frame is exactly three bytes: a command byte (0xAA or 0x55) and two argument bytes. Argument bytes are taken as data even if they equal 0xAA or 0x55, and each frame causes at most one action.
- R5: Frame {0xAA, 0x00, any} raises `cnt_clear` for exactly one clock cycle.
- R6: Frame {0xAA, 0x01, any} queues the reply 0x55, low byte of `cnt0`, high byte of `cnt0`. The transfer right after the frame still carries the filler, and the three reply bytes follow in the next three transfers.
- R7: Frame {0xAA, 0x02, any} queues the reply 0x56, low byte of `cnt1`, high byte of `cnt1`, with the same timing as R6.
- R8: Frame {0x55, a, b} loads duty channel 0 from a and duty channel 1 from b. It raises `duty_update` for exactly one cycle, in the cycle the new values appear. The duty outputs change at no other time.
- R9: A loaded duty value below 3 becomes 3 and one above 253 becomes 253. Values 3 to 253 pass unchanged, and both duty outputs reset to 3.
- R10: After the third byte of a reply has been shifted out, the queue is empty and the filler byte 0xEE is sent again.
- R11: The counter value is captured in the cycle the readback command is decoded. Later counter changes do not alter the queued reply.
- R12: Raising `cs_n` during a byte discards the partial byte and restarts bit counting. Raising it during a frame abandons that frame, so the next byte must again be a command byte.
- R13: A frame with command 0xAA and an argument other than 0x00, 0x01 or 0x02 is dropped: no strobe, no reply, no duty change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host, idles low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| cnt0 | input | 16 | Quadrature counter 0 value |
| cnt1 | input | 16 | Quadrature counter 1 value |
| cnt_clear | output | 1 | One-cycle strobe to zero both counters |
| duty0 | output | 8 | Clamped duty value, channel 0 |
| duty1 | output | 8 | Clamped duty value, channel 1 |
| duty_update | output | 1 | One-cycle strobe marking newly loaded duty values |

## Verification
The last falling `sclk` edge of a byte reaches the decoder about four system cycles later: two synchroniser stages, the edge register and the byte-valid register. `cnt_clear` and the queued reply follow one cycle after that, and the clamped duty values with `duty_update` one cycle later again. The bench therefore checks strobes with counters that watch every clock edge, and reads duty outputs only after chip select has been high for twenty cycles. `miso` changes within about four cycles of a rising `sclk` edge. The bench holds each `sclk` level for ten cycles and samples `miso` just before the falling edge, on the inactive clock edge. Reply checks count transfers from the end of the command frame: the first transfer after the frame must return filler, and the reply occupies the three transfers after that.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam logic [7:0] FILL_BYTE  = 8'hEE;
  localparam logic [7:0] CMD_QUERY  = 8'hAA;
  localparam logic [7:0] CMD_DUTY   = 8'h55;
  localparam logic [7:0] SUB_ZERO   = 8'h00;
  localparam logic [7:0] SUB_READ0  = 8'h01;
  localparam logic [7:0] SUB_READ1  = 8'h02;
  localparam logic [7:0] TAG_READ0  = 8'h55;
  localparam logic [7:0] TAG_READ1  = 8'h56;

  typedef enum logic [1:0] {
    GATHER_IDLE = 2'd0,
    GATHER_ARG1 = 2'd1,
    GATHER_ARG2 = 2'd2
  } gather_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  input  logic [W-1:0] rst_val,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= rst_val;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_mode1_shifter.sv
module spi_mode1_shifter #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  input  logic [DW-1:0] tx_byte,
  output logic          miso,
  output logic          rx_valid,
  output logic [DW-1:0] rx_byte,
  output logic          deselected
);
  localparam int BW = $clog2(DW);

  logic [2:0]    pins_s;
  logic          sclk_d;
  logic          sclk_rise, sclk_fall;
  logic [BW-1:0] bit_idx;
  logic [DW-1:0] tx_sh, rx_sh;

  pin_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d       ({cs_n, sclk, mosi}),
    .rst_val (3'b100),
    .q       (pins_s)
  );

  assign deselected = pins_s[2];
  assign sclk_rise  =  pins_s[1] & ~sclk_d;
  assign sclk_fall  = ~pins_s[1] &  sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b0;
      bit_idx  <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      miso     <= 1'b0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
    end else begin
      rx_valid <= 1'b0;
      sclk_d   <= pins_s[1];
      if (deselected) begin
        bit_idx <= '0;
      end else begin
        if (sclk_rise) begin
          if (bit_idx == '0) begin
            miso  <= tx_byte[DW-1];
            tx_sh <= {tx_byte[DW-2:0], 1'b0};
          end else begin
            miso  <= tx_sh[DW-1];
            tx_sh <= {tx_sh[DW-2:0], 1'b0};
          end
        end
        if (sclk_fall) begin
          rx_sh <= {rx_sh[DW-2:0], pins_s[0]};
          if (bit_idx == BW'(DW-1)) begin
            bit_idx  <= '0;
            rx_valid <= 1'b1;
            rx_byte  <= {rx_sh[DW-2:0], pins_s[0]};
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cmd_frame_engine.sv
module cmd_frame_engine
  import spi_cmd_pkg::*;
#(
  parameter int DW        = 8,
  parameter int CW        = 16,
  parameter int FRAME_LEN = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_valid,
  input  logic [DW-1:0]        rx_byte,
  input  logic                 deselected,
  input  logic [CW-1:0]        cnt0,
  input  logic [CW-1:0]        cnt1,
  output logic [DW-1:0]        tx_byte,
  output logic                 clr_pulse,
  output logic                 load_pulse,
  output logic [1:0][DW-1:0]   raw_duty
);
  localparam int IW = $clog2(FRAME_LEN);

  gather_t       state;
  logic [DW-1:0] cmd_q, arg1_q;
  logic [DW-1:0] reply_q [FRAME_LEN];
  logic [IW-1:0] tx_idx;
  logic          pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= GATHER_IDLE;
      cmd_q      <= '0;
      arg1_q     <= '0;
      tx_byte    <= FILL_BYTE;
      tx_idx     <= '0;
      pending    <= 1'b0;
      clr_pulse  <= 1'b0;
      load_pulse <= 1'b0;
      raw_duty   <= '0;
      for (int i = 0; i < FRAME_LEN; i++) reply_q[i] <= '0;
    end else begin
      clr_pulse  <= 1'b0;
      load_pulse <= 1'b0;
      if (rx_valid) begin
        // byte for the following transfer, chosen before this byte is decoded
        if (pending) begin
          tx_byte <= reply_q[tx_idx];
          if (tx_idx == IW'(FRAME_LEN-1)) begin
            tx_idx  <= '0;
            pending <= 1'b0;
          end else begin
            tx_idx <= tx_idx + 1'b1;
          end
        end else begin
          tx_byte <= FILL_BYTE;
        end

        case (state)
          GATHER_IDLE: begin
            if (rx_byte == CMD_QUERY || rx_byte == CMD_DUTY) begin
              cmd_q <= rx_byte;
              state <= GATHER_ARG1;
            end
          end
          GATHER_ARG1: begin
            arg1_q <= rx_byte;
            state  <= GATHER_ARG2;
          end
          default: begin
            state <= GATHER_IDLE;
            if (cmd_q == CMD_DUTY) begin
              raw_duty[0] <= arg1_q;
              raw_duty[1] <= rx_byte;
              load_pulse  <= 1'b1;
            end else begin
              case (arg1_q)
                SUB_ZERO: clr_pulse <= 1'b1;
                SUB_READ0: begin
                  reply_q[0] <= TAG_READ0;
                  reply_q[1] <= cnt0[DW-1:0];
                  reply_q[2] <= cnt0[CW-1:DW];
                  tx_idx     <= '0;
                  pending    <= 1'b1;
                end
                SUB_READ1: begin
                  reply_q[0] <= TAG_READ1;
                  reply_q[1] <= cnt1[DW-1:0];
                  reply_q[2] <= cnt1[CW-1:DW];
                  tx_idx     <= '0;
                  pending    <= 1'b1;
                end
                default: ;
              endcase
            end
          end
        endcase
      end
      if (deselected) state <= GATHER_IDLE;
    end
  end
endmodule

// File: rtl/duty_clamp.sv
module duty_clamp #(
  parameter int DW    = 8,
  parameter int NCH   = 2,
  parameter int MIN_V = 3,
  parameter int MAX_V = 253
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [NCH-1:0][DW-1:0] raw,
  output logic [NCH-1:0][DW-1:0] duty,
  output logic                 upd
);
  localparam logic [DW-1:0] LO = DW'(MIN_V);
  localparam logic [DW-1:0] HI = DW'(MAX_V);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)                duty[c] <= LO;
      else if (load) begin
        if (raw[c] < LO)      duty[c] <= LO;
        else if (raw[c] > HI) duty[c] <= HI;
        else                  duty[c] <= raw[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) upd <= 1'b0;
    else     upd <= load;
  end
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder #(
  parameter int DW          = 8,
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DUTY_MIN    = 3,
  parameter int DUTY_MAX    = 253
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  output logic          miso,
  input  logic [CW-1:0] cnt0,
  input  logic [CW-1:0] cnt1,
  output logic          cnt_clear,
  output logic [DW-1:0] duty0,
  output logic [DW-1:0] duty1,
  output logic          duty_update
);
  localparam int FRAME_LEN = 3;
  localparam int NCH       = 2;

  logic                    rx_valid, deselected, load_pulse;
  logic [DW-1:0]           rx_byte, tx_byte;
  logic [NCH-1:0][DW-1:0]  raw_duty, duty_vec;

  spi_mode1_shifter #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .sclk       (sclk),
    .cs_n       (cs_n),
    .mosi       (mosi),
    .tx_byte    (tx_byte),
    .miso       (miso),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .deselected (deselected)
  );

  cmd_frame_engine #(.DW(DW), .CW(CW), .FRAME_LEN(FRAME_LEN)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .deselected (deselected),
    .cnt0       (cnt0),
    .cnt1       (cnt1),
    .tx_byte    (tx_byte),
    .clr_pulse  (cnt_clear),
    .load_pulse (load_pulse),
    .raw_duty   (raw_duty)
  );

  duty_clamp #(.DW(DW), .NCH(NCH), .MIN_V(DUTY_MIN), .MAX_V(DUTY_MAX)) u_clamp (
    .clk  (clk),
    .rst  (rst),
    .load (load_pulse),
    .raw  (raw_duty),
    .duty (duty_vec),
    .upd  (duty_update)
  );

  assign duty0 = duty_vec[0];
  assign duty1 = duty_vec[1];
endmodule

// File: rtl/spi_cmd_decoder_chk.sv
module spi_cmd_decoder_chk #(
  parameter int DW       = 8,
  parameter int DUTY_MIN = 3,
  parameter int DUTY_MAX = 253
) (
  input logic          clk,
  input logic          rst,
  input logic          cnt_clear,
  input logic          duty_update,
  input logic [DW-1:0] duty0,
  input logic [DW-1:0] duty1
);
  p_clear_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_clear |=> !cnt_clear);

  p_update_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    duty_update |=> !duty_update);

  p_duty0_moves_r8: assert property (@(posedge clk) disable iff (rst)
    (duty0 != $past(duty0)) |-> duty_update);

  p_duty1_moves_r8: assert property (@(posedge clk) disable iff (rst)
    (duty1 != $past(duty1)) |-> duty_update);

  p_duty0_window_r9: assert property (@(posedge clk) disable iff (rst)
    (duty0 >= DW'(DUTY_MIN)) && (duty0 <= DW'(DUTY_MAX)));

  p_duty1_window_r9: assert property (@(posedge clk) disable iff (rst)
    (duty1 >= DW'(DUTY_MIN)) && (duty1 <= DW'(DUTY_MAX)));

  p_one_action_r4: assert property (@(posedge clk) disable iff (rst)
    !(cnt_clear && duty_update));
endmodule

bind spi_cmd_decoder spi_cmd_decoder_chk #(.DW(DW), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cnt_clear   (cnt_clear),
  .duty_update (duty_update),
  .duty0       (duty0),
  .duty1       (duty1)
);

// File: tb/tb_spi_cmd_decoder.sv
module tb_spi_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic        miso;
  logic [15:0] cnt0 = 16'h0000;
  logic [15:0] cnt1 = 16'h0000;
  logic        cnt_clear;
  logic [7:0]  duty0, duty1;
  logic        duty_update;

  int n_chk = 0;
  int n_fail = 0;
  int clr_seen = 0;
  int upd_seen = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_cmd_decoder dut (
    .clk (clk), .rst (rst), .sclk (sclk), .cs_n (cs_n), .mosi (mosi),
    .miso (miso), .cnt0 (cnt0), .cnt1 (cnt1), .cnt_clear (cnt_clear),
    .duty0 (duty0), .duty1 (duty1), .duty_update (duty_update)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (cnt_clear)   clr_seen++;
      if (duty_update) upd_seen++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_open();
    @(negedge clk); cs_n = 1'b0; idle(4);
  endtask

  task automatic cs_close();
    idle(4); cs_n = 1'b1; idle(20);
  endtask

  // host side of mode 1: drive on rising sclk, sample miso before falling sclk
  task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      @(negedge clk); sclk = 1'b1; mosi = tx[i];
      idle(10);
      rx[i] = miso; sclk = 1'b0;
      idle(10);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xfer_bits(tx, 8, rx);
  endtask

  task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    logic [7:0] r;
    cs_open();
    xfer(b0, r); xfer(b1, r); xfer(b2, r);
    cs_close();
  endtask

  task automatic expect_reply(input string tag, input logic [7:0] e1, e2, e3);
    logic [7:0] r;
    cs_open();
    xfer(8'h00, r); chk({tag, " filler first"}, r, 8'hEE);
    xfer(8'h00, r); chk({tag, " tag byte"}, r, e1);
    xfer(8'h00, r); chk({tag, " low byte"}, r, e2);
    xfer(8'h00, r); chk({tag, " high byte"}, r, e3);
    xfer(8'h00, r); chk("R10 filler resumes", r, 8'hEE);
    cs_close();
  endtask

  task automatic t_reset();
    logic [7:0] r;
    chk("R9 reset duty0", duty0, 3);
    chk("R9 reset duty1", duty1, 3);
    chk("R5 reset clear low", cnt_clear, 0);
    chk("R8 reset update low", duty_update, 0);
    cs_open(); xfer(8'h00, r); cs_close();
    chk("R2 first transfer filler", r, 8'hEE);
  endtask

  task automatic t_duty_load();
    int u = upd_seen; int c = clr_seen;
    frame(8'h55, 8'h12, 8'h34);
    chk("R8 R1 duty0 load", duty0, 8'h12);
    chk("R8 R1 duty1 load", duty1, 8'h34);
    chk("R8 one update strobe", upd_seen - u, 1);
    chk("R4 no clear on duty frame", clr_seen - c, 0);
  endtask

  task automatic t_clamp();
    frame(8'h55, 8'h01, 8'hFF);
    chk("R9 clamp low 01", duty0, 3);  chk("R9 clamp high FF", duty1, 253);
    frame(8'h55, 8'h02, 8'hFE);
    chk("R9 clamp low 02", duty0, 3);  chk("R9 clamp high FE", duty1, 253);
    frame(8'h55, 8'h00, 8'h80);
    chk("R9 clamp zero", duty0, 3);    chk("R9 mid pass", duty1, 8'h80);
    frame(8'h55, 8'h03, 8'hFD);
    chk("R9 edge 03 passes", duty0, 3); chk("R9 edge FD passes", duty1, 253);
    frame(8'h55, 8'h04, 8'hFC);
    chk("R9 inside 04", duty0, 4);     chk("R9 inside FC", duty1, 252);
  endtask

  task automatic t_sync();
    logic [7:0] r;
    int u = upd_seen;
    cs_open();
    xfer(8'h00, r); xfer(8'h12, r); xfer(8'h34, r);
    xfer(8'h55, r); xfer(8'h80, r); xfer(8'h90, r);
    cs_close();
    chk("R3 junk skipped duty0", duty0, 8'h80);
    chk("R3 junk skipped duty1", duty1, 8'h90);
    chk("R3 single update", upd_seen - u, 1);
  endtask

  task automatic t_inframe();
    int c = clr_seen;
    frame(8'h55, 8'hAA, 8'h55);
    chk("R4 arg AA is data", duty0, 8'hAA);
    chk("R4 arg 55 is data", duty1, 8'h55);
    chk("R4 no extra action", clr_seen - c, 0);
  endtask

  task automatic t_clear();
    int c = clr_seen; int u = upd_seen;
    frame(8'hAA, 8'h00, 8'h5A);
    chk("R5 one clear strobe", clr_seen - c, 1);
    chk("R5 no update on clear", upd_seen - u, 0);
  endtask

  task automatic t_read0();
    cnt0 = 16'hBEEF;
    frame(8'hAA, 8'h01, 8'h00);
    cnt0 = 16'h1234;
    expect_reply("R6 R11 R1 counter0", 8'h55, 8'hEF, 8'hBE);
  endtask

  task automatic t_read1();
    cnt1 = 16'h0A0B;
    frame(8'hAA, 8'h02, 8'h00);
    cnt1 = 16'hFFFF;
    expect_reply("R7 R11 counter1", 8'h56, 8'h0B, 8'h0A);
  endtask

  task automatic t_unknown();
    logic [7:0] r;
    int c = clr_seen; int u = upd_seen;
    logic [7:0] d0 = duty0; logic [7:0] d1 = duty1;
    frame(8'hAA, 8'h07, 8'h00);
    cs_open();
    for (int k = 0; k < 4; k++) begin
      xfer(8'h00, r);
      chk("R13 no reply queued", r, 8'hEE);
    end
    cs_close();
    chk("R13 no clear", clr_seen - c, 0);
    chk("R13 no update", upd_seen - u, 0);
    chk("R13 duty0 kept", duty0, d0);
    chk("R13 duty1 kept", duty1, d1);
  endtask

  task automatic t_abort();
    logic [7:0] r;
    int c = clr_seen;
    cs_open(); xfer_bits(8'hF0, 4, r); cs_close();
    frame(8'h55, 8'h21, 8'h43);
    chk("R12 partial byte dropped duty0", duty0, 8'h21);
    chk("R12 partial byte dropped duty1", duty1, 8'h43);
    cs_open(); xfer(8'hAA, r); xfer(8'h00, r); cs_close();
    frame(8'h55, 8'h65, 8'h87);
    chk("R12 frame restart duty0", duty0, 8'h65);
    chk("R12 frame restart duty1", duty1, 8'h87);
    chk("R12 abandoned frame no clear", clr_seen - c, 0);
  endtask

  initial begin
    idle(5);
    rst = 1'b0;
    idle(5);
    t_reset();
    t_duty_load();
    t_clamp();
    t_sync();
    t_inframe();
    t_clear();
    t_read0();
    t_read1();
    t_unknown();
    t_abort();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule